// File: doc/BRIEF.md
# Two-Stage Watchdog with Absolute Deadline Compare

This block is a watchdog for a processor subsystem. It does not count down. It holds a 64-bit deadline and compares it each cycle against a free-running 64-bit system tick count that arrives from outside. Software sets a period in a 32-bit offset register and then enables the watchdog. The block places the deadline one period ahead of the current tick count. If software does not refresh it in time, the block escalates in two steps.

The first miss raises an interrupt and moves the deadline one more period ahead. A second miss asserts a reset request, which stays set until the block itself is reset. The worst-case time from the last refresh to the reset request is therefore two periods. Software refreshes the watchdog by writing any value to a register in a separate refresh frame, which can be mapped apart from the control registers. Both frames return the same identification word.

Access uses a simple single-cycle bus. A request carries a frame select, a 3-bit word index and a write flag. Read data is combinational and depends only on the current request.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset both outputs are low, and the control word, offset and both deadline words all read as 0.
- R2: Register map. Frame 0 (control) word 0 is the control/status word (bit 0 enable, bit 1 first-stage flag, bit 2 second-stage flag), word 1 is the offset, word 2 is deadline bits 31:0, word 3 is deadline bits 63:32 and word 7 is identification. Frame 1 (refresh) word 0 is the refresh register and word 7 is identification. Unmapped words read 0.
- R3: Writing enable as 1 while it is 0 sets the deadline to the tick count sampled at that write plus the offset, and clears both stage flags.
- R4: While enabled with the first-stage flag clear, a tick count at or above the deadline sets the first-stage flag. The interrupt output is high from the next cycle, and the deadline becomes that tick count plus the offset.
- R5: While enabled with the first-stage flag set, a tick count at or above the deadline sets the second-stage flag, which drives the reset request.
- R6: A write of any value to the refresh register sets the deadline to the tick count plus the offset and clears the first-stage flag.
- R7: A write to the offset register stores the value and sets the deadline to the tick count plus the new offset.
- R8: Once the second-stage flag is set, refresh, offset and control writes have no effect, and both outputs stay high until reset.
- R9: While disabled, no stage flag is set and both outputs are low. Writing enable as 0 clears the first-stage flag.
- R10: Writes to either deadline word replace that half directly, read back as written, and leave the stage flags unchanged.
- R11: The identification word carries a version in bits 31:16, a continuation code in bits 11:8 and an identity code in bits 7:0, and bits 15:12 are 0.
- R12: The deadline comparison is unsigned over the full 64 bits, so a nonzero upper word holds off expiry while the tick count is below 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_cnt | input | 64 | Free-running system tick count |
| bus_valid | input | 1 | Bus request valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_frame | input | 1 | 0 = control frame, 1 = refresh frame |
| bus_addr | input | 3 | Word index within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| wd_irq | output | 1 | First-stage flag (interrupt) |
| wd_reset_req | output | 1 | Second-stage flag (reset request) |

## Verification
The bench aims at the exact cycle of each expiry. It checks one cycle before and the cycle after the tick count reaches the deadline, so a design that compares with strict greater-than, or that is off by a register stage, reports too late. It refreshes during the first stage to show the interrupt drops and a full new period starts. It then lets the watchdog run to the reset request and tries refresh, disable and offset writes, which a design without the stage-1 lock would obey. Further cases cover deadline writes that must not clear a set flag, an offset write that must restart the timeout, and an upper deadline word of 1 that a design comparing only 32 bits would wrongly expire on.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] WA_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] WA_OFFS  = 3'd1;
  localparam logic [ADDR_W-1:0] WA_DLO   = 3'd2;
  localparam logic [ADDR_W-1:0] WA_DHI   = 3'd3;
  localparam logic [ADDR_W-1:0] WA_IDENT = 3'd7;
  localparam logic [ADDR_W-1:0] WA_KICK  = 3'd0;

  typedef struct packed {
    logic ctrl;
    logic offs;
    logic dlo;
    logic dhi;
    logic kick;
  } wstb_t;

  function automatic logic [31:0] ident_word(input logic [15:0] ver,
                                             input logic [3:0]  cont,
                                             input logic [7:0]  idc);
    return {ver, 4'b0000, cont, idc};
  endfunction
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
  import wdog_pkg::*;
(
  input  logic              valid,
  input  logic              write,
  input  logic              frame,
  input  logic [ADDR_W-1:0] addr,
  output wstb_t             wstb,
  output logic              rd_en
);
  logic wr_ctl_frame;
  logic wr_kick_frame;

  always_comb begin
    wr_ctl_frame  = valid & write & ~frame;
    wr_kick_frame = valid & write & frame;
    wstb.ctrl = wr_ctl_frame & (addr == WA_CTRL);
    wstb.offs = wr_ctl_frame & (addr == WA_OFFS);
    wstb.dlo  = wr_ctl_frame & (addr == WA_DLO);
    wstb.dhi  = wr_ctl_frame & (addr == WA_DHI);
    wstb.kick = wr_kick_frame & (addr == WA_KICK);
    rd_en     = valid & ~write;
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] sys_cnt,
  input  wstb_t         wstb,
  input  logic [DW-1:0] wdata,
  output logic          en_q,
  output logic [DW-1:0] off_q,
  output logic [CW-1:0] cmp_q,
  output logic          st0_q,
  output logic          st1_q
);
  logic          lock;
  logic          ctl_wr;
  logic          en_d;
  logic          en_rise;
  logic          stop;
  logic          off_wr;
  logic [DW-1:0] off_d;
  logic          reload;
  logic          due;
  logic [CW-1:0] deadline;
  logic          cmp_ld;
  logic [CW-1:0] cmp_d;
  logic          st0_d;
  logic          st1_d;

  // next-state logic
  always_comb begin
    lock     = st1_q;
    ctl_wr   = wstb.ctrl & ~lock;
    en_d     = ctl_wr ? wdata[0] : en_q;
    en_rise  = ctl_wr & wdata[0] & ~en_q;
    stop     = ctl_wr & ~wdata[0];
    off_wr   = wstb.offs & ~lock;
    off_d    = off_wr ? wdata : off_q;
    reload   = (wstb.kick | off_wr | en_rise) & ~lock;
    due      = en_q & (sys_cnt >= cmp_q);
    deadline = sys_cnt + {{(CW-DW){1'b0}}, off_d};
    cmp_ld   = reload | wstb.dlo | wstb.dhi | (due & ~st0_q);

    if (reload)         cmp_d = deadline;
    else if (wstb.dlo)  cmp_d = {cmp_q[CW-1:DW], wdata};
    else if (wstb.dhi)  cmp_d = {wdata, cmp_q[DW-1:0]};
    else                cmp_d = deadline;

    if (stop || reload)        st0_d = 1'b0;
    else if (due && !st0_q)    st0_d = 1'b1;
    else                       st0_d = st0_q;

    if (stop || reload)        st1_d = 1'b0;
    else if (due && st0_q)     st1_d = 1'b1;
    else                       st1_d = st1_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      off_q <= '0;
      cmp_q <= '0;
      st0_q <= 1'b0;
      st1_q <= 1'b0;
    end else begin
      if (ctl_wr) en_q  <= en_d;
      if (off_wr) off_q <= off_d;
      if (cmp_ld) cmp_q <= cmp_d;
      st0_q <= st0_d;
      st1_q <= st1_d;
    end
  end

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!st0_q && !st1_q));

  a_r8_stage1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    st1_q |=> (st1_q && st0_q && en_q));

  a_r5_escalate_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st1_q) |-> ($past(st0_q) && st0_q));

  a_r6_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wstb.kick && !st1_q) |=> !st0_q);

  a_r10_cmp_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ((wstb.dlo || wstb.dhi) && st0_q) |=> st0_q);

  a_r4_reload_on_stage0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st0_q) |-> (cmp_q == $past(sys_cnt) + {{(CW-DW){1'b0}}, off_q}));
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
  import wdog_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 2 * DW,
  parameter logic [DW-1:0] IDENT = '0
) (
  input  logic              rd_en,
  input  logic              frame,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic              st0,
  input  logic              st1,
  input  logic [DW-1:0]     off,
  input  logic [CW-1:0]     cmp,
  output logic [DW-1:0]     rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (!frame) begin
        case (addr)
          WA_CTRL:  rdata = {{(DW-3){1'b0}}, st1, st0, en};
          WA_OFFS:  rdata = off;
          WA_DLO:   rdata = cmp[DW-1:0];
          WA_DHI:   rdata = cmp[CW-1:DW];
          WA_IDENT: rdata = IDENT;
          default:  rdata = '0;
        endcase
      end else begin
        if (addr == WA_IDENT) rdata = IDENT;
      end
    end
  end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int          DW      = 32,
  parameter logic [15:0] ID_VER  = 16'h0102,
  parameter logic [3:0]  ID_CONT = 4'h3,
  parameter logic [7:0]  ID_CODE = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*DW-1:0]   sys_cnt,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_frame,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              wd_irq,
  output logic              wd_reset_req
);
  localparam int CW = 2 * DW;
  localparam logic [DW-1:0] IDENT = DW'(ident_word(ID_VER, ID_CONT, ID_CODE));

  wstb_t         wstb;
  logic          rd_en;
  logic          en_q;
  logic [DW-1:0] off_q;
  logic [CW-1:0] cmp_q;
  logic          st0_q;
  logic          st1_q;

  wdog_decode u_dec (
    .valid (bus_valid),
    .write (bus_write),
    .frame (bus_frame),
    .addr  (bus_addr),
    .wstb  (wstb),
    .rd_en (rd_en)
  );

  wdog_timer #(.DW(DW), .CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .sys_cnt (sys_cnt),
    .wstb    (wstb),
    .wdata   (bus_wdata),
    .en_q    (en_q),
    .off_q   (off_q),
    .cmp_q   (cmp_q),
    .st0_q   (st0_q),
    .st1_q   (st1_q)
  );

  wdog_rdmux #(.DW(DW), .CW(CW), .IDENT(IDENT)) u_rd (
    .rd_en (rd_en),
    .frame (bus_frame),
    .addr  (bus_addr),
    .en    (en_q),
    .st0   (st0_q),
    .st1   (st1_q),
    .off   (off_q),
    .cmp   (cmp_q),
    .rdata (bus_rdata)
  );

  assign wd_irq       = st0_q;
  assign wd_reset_req = st1_q;

  a_r9_outputs_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!wd_irq && !wd_reset_req));

  a_r8_reset_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset_req |=> (wd_reset_req && wd_irq));
endmodule

// File: tb/tb_wdog_two_stage.sv
module tb_wdog_two_stage;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EXP_IDENT = 32'h0102035A;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] sys_cnt;
  logic        bus_valid, bus_write, bus_frame;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        wd_irq, wd_reset_req;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  typedef struct {
    int    when;
    bit    irq;
    bit    rst;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign sys_cnt = 64'(cyc);

  wdog_two_stage dut (
    .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_frame(bus_frame),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_irq(wd_irq), .wd_reset_req(wd_reset_req)
  );

  function automatic void report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endfunction

  // monitor: pops expected output items at their cycle
  always @(negedge clk) begin
    if (!done) begin
      while (exp_q.size() > 0 && exp_q[0].when < cyc) begin
        n_chk++; n_err++;
        $display("FAIL %s: expectation for cycle %0d missed (actual cycle %0d, expected that cycle)",
                 exp_q[0].tag, exp_q[0].when, cyc);
        void'(exp_q.pop_front());
      end
      while (exp_q.size() > 0 && exp_q[0].when == cyc) begin
        n_chk++;
        if (wd_irq !== exp_q[0].irq || wd_reset_req !== exp_q[0].rst) begin
          n_err++;
          $display("FAIL %s: cycle %0d actual irq=%0b rst=%0b expected irq=%0b rst=%0b",
                   exp_q[0].tag, cyc, wd_irq, wd_reset_req, exp_q[0].irq, exp_q[0].rst);
        end
        void'(exp_q.pop_front());
      end
      if (cyc > 50000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog: actual cycle %0d expected finish before 50000", cyc);
        done = 1;
        report();
        $finish;
      end
    end
  end

  task automatic expect_out(input int when, input bit irq, input bit rst, input string tag);
    exp_t e;
    e.when = when; e.irq = irq; e.rst = rst; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // write; rel adds the current tick count to the data; k = tick count sampled by the write
  task automatic bus_wr(input bit fr, input logic [2:0] a, input logic [31:0] d,
                        input bit rel, output int k);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_frame = fr; bus_addr = a;
    bus_wdata = rel ? d + 32'(cyc) : d;
    k = cyc;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input bit fr, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_frame = fr; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    int k, k2, j, m, w;
    logic [31:0] rd;
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_frame = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk("R1 irq", 32'(wd_irq), 0);
    chk("R1 reset_req", 32'(wd_reset_req), 0);
    bus_rd(0, 3'd0, rd); chk("R1 ctrl", rd, 0);
    bus_rd(0, 3'd1, rd); chk("R1 offset", rd, 0);
    bus_rd(0, 3'd2, rd); chk("R1 deadline lo", rd, 0);
    bus_rd(0, 3'd3, rd); chk("R1 deadline hi", rd, 0);

    // R9 disabled: offset write does not start anything
    bus_wr(0, 3'd1, 32'd10, 0, k);
    expect_out(k + 11, 0, 0, "R9 disabled no stage0");
    expect_out(k + 21, 0, 0, "R9 disabled no stage1");
    drain();
    bus_rd(0, 3'd0, rd); chk("R9 ctrl idle", rd, 0);
    bus_rd(0, 3'd1, rd); chk("R2 offset readback", rd, 32'd10);

    // R3 enable, R6 refresh before expiry, R4 first expiry
    bus_wr(0, 3'd0, 32'd1, 0, k);
    expect_out(k + 11, 0, 0, "R6 refresh pushed deadline");
    wait_until(k + 5);
    bus_wr(1, 3'd0, 32'hDEAD_BEEF, 0, k2);
    expect_out(k2 + 10, 0, 0, "R4 one cycle before expiry");
    expect_out(k2 + 11, 1, 0, "R4 stage0 at deadline");
    drain();
    bus_rd(0, 3'd0, rd); chk("R2 ctrl stage0", rd, 32'd3);
    bus_rd(0, 3'd2, rd); chk("R4 deadline reloaded", rd, 32'(k2 + 20));

    // R6 refresh during stage0 clears it; R5 escalation after two periods
    bus_wr(1, 3'd0, 32'd0, 0, j);
    expect_out(j + 1, 0, 0, "R6 refresh clears stage0");
    expect_out(j + 10, 0, 0, "R4 before second expiry");
    expect_out(j + 11, 1, 0, "R4 stage0 again");
    expect_out(j + 20, 1, 0, "R5 one cycle before reset req");
    expect_out(j + 21, 1, 1, "R5 reset request");
    drain();
    bus_rd(0, 3'd0, rd); chk("R5 ctrl both stages", rd, 32'd7);

    // R8 lock after stage1
    bus_wr(1, 3'd0, 32'd0, 0, m);
    expect_out(m + 1, 1, 1, "R8 refresh ignored");
    drain();
    bus_wr(0, 3'd0, 32'd0, 0, m);
    expect_out(m + 1, 1, 1, "R8 disable ignored");
    drain();
    bus_wr(0, 3'd1, 32'd3, 0, m);
    bus_rd(0, 3'd1, rd); chk("R8 offset unchanged", rd, 32'd10);
    bus_rd(0, 3'd0, rd); chk("R8 ctrl still enabled", rd, 32'd7);

    do_reset();
    @(negedge clk);
    chk("R1 reset clears reset_req", 32'(wd_reset_req), 0);

    // R7 offset write restarts with new period
    bus_wr(0, 3'd1, 32'd20, 0, k);
    bus_wr(0, 3'd0, 32'd1, 0, k);
    wait_until(k + 4);
    bus_wr(0, 3'd1, 32'd6, 0, k2);
    expect_out(k2 + 6, 0, 0, "R7 before new deadline");
    expect_out(k2 + 7, 1, 0, "R7 stage0 from new offset");
    drain();

    // R9 disable clears stage0 and stays quiet
    bus_wr(0, 3'd0, 32'd0, 0, w);
    expect_out(w + 1, 0, 0, "R9 disable clears stage0");
    expect_out(w + 30, 0, 0, "R9 stays quiet");
    drain();
    bus_rd(0, 3'd0, rd); chk("R9 ctrl after disable", rd, 0);

    // R10 direct deadline write
    bus_wr(0, 3'd0, 32'd1, 0, k);
    bus_wr(0, 3'd2, 32'd3, 1, k2);
    expect_out(k2 + 3, 0, 0, "R10 before written deadline");
    expect_out(k2 + 4, 1, 0, "R10 written deadline expires");
    drain();
    bus_rd(0, 3'd2, rd); chk("R4 deadline after stage0", rd, 32'(k2 + 9));
    bus_wr(0, 3'd2, 32'd100, 1, w);
    expect_out(w + 1, 1, 0, "R10 write keeps stage0");
    drain();
    bus_rd(0, 3'd2, rd); chk("R10 deadline lo readback", rd, 32'(w + 100));
    bus_wr(0, 3'd0, 32'd0, 0, w);

    // R12 full 64-bit compare
    bus_wr(0, 3'd1, 32'd10, 0, k);
    bus_wr(0, 3'd0, 32'd1, 0, k);
    bus_wr(0, 3'd3, 32'd1, 0, k2);
    expect_out(k + 40, 0, 0, "R12 upper word holds off expiry");
    drain();
    bus_rd(0, 3'd3, rd); chk("R12 deadline hi readback", rd, 32'd1);
    bus_wr(0, 3'd0, 32'd0, 0, w);

    // R11 identification in both frames, R2 unmapped reads
    bus_rd(0, 3'd7, rd); chk("R11 ident control frame", rd, EXP_IDENT);
    bus_rd(1, 3'd7, rd); chk("R11 ident refresh frame", rd, EXP_IDENT);
    bus_rd(0, 3'd5, rd); chk("R2 unmapped word", rd, 0);

    repeat (2) @(negedge clk);
    done = 1;
    report();
    $finish;
  end
endmodule